// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM

This block is a synchronous single-port memory with a built-in array. Its command timing keeps the data path busy every cycle for any mix of reads and writes. A read command returns its word one enabled clock edge after the command edge. A write command takes its data two enabled edges after the command edge. Because the write data lags its command by the same amount as the read data, a host can alternate reads and writes every cycle and never leave an idle bus slot.

Commands are started by a load strobe and qualified by three chip selects. The advance strobe continues the last command at the next address of a four-beat burst. The burst order is either a wrapping increment or an XOR of the start offset. A clock-enable input freezes the whole block for a cycle. The output-enable input is asynchronous and only gates the drive-enable output. A read that follows a write to the same word closely enough returns the new bytes, taken from the write still in flight.

Top module: `zt_sram`

## Requirements
- R1: A command starts on an enabled edge only when advLd=0, sel1N=0, sel2=1 and sel3N=0. With advLd=0 and any select inactive, the edge is a deselect: it produces no read result and writes nothing.
- R2: On an edge where ceN=1, every input is ignored and all state holds. This includes the output word, the drive state and the pending write steps, and the dIn value at that edge is not written.
- R3: A read (weN=1) issued at enabled edge k puts the addressed word on dOut after enabled edge k+1. The word stays there until the next enabled edge.
- R4: A write (weN=0) issued at enabled edge k writes dIn at enabled edge k+2. Byte lane i is bits [9i+8:9i] and is written only when bwN[i]=0.
- R5: A write with bwN all ones is an abort and changes no stored bit.
- R6: With advLd=1 after a read or write, the same operation repeats at the next burst address. Address bits above bit 1 stay equal to the start address. With burstXor=0 the low two bits are (start+n) mod 4. With burstXor=1 they are start XOR n, where n is the beat count since the load, modulo 4, so the fifth beat wraps back to the start.
- R7: With advLd=1 after a deselect, the block stays deselected: no read result appears and no write takes place.
- R8: dOutEn is 1 only while oeN=0 and a read result is held. It follows oeN without waiting for a clock edge. A read issued with oeN=1 still moves through the pipeline and is driven once oeN drops while the result is held.
- R9: A read whose array access falls on the data edge of an earlier write to the same address returns the new bytes in the enabled lanes and the old bytes in the other lanes.
- R10: Reads and writes may alternate on consecutive enabled edges with no idle cycle, and every read returns the correct data.
- R11: After reset, dOutEn is 0 and the block is in the deselected state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the control and pipeline state |
| ceN | input | 1 | Clock enable, active low; 1 freezes the block for that edge |
| sel1N | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3N | input | 1 | Chip select, active low |
| advLd | input | 1 | 0 loads a new command, 1 advances the burst |
| weN | input | 1 | 1 read, 0 write |
| bwN | input | LANES | Byte write enables, active low, one per lane |
| burstXor | input | 1 | Burst order: 0 wrapping increment, 1 XOR |
| addr | input | ADDR_W | Word address |
| dIn | input | LANES*LANE_W | Write data, sampled two enabled edges after its command |
| oeN | input | 1 | Asynchronous output enable, active low |
| dOut | output | LANES*LANE_W | Read data from the output register |
| dOutEn | output | 1 | Drive enable for dOut |

## Verification
The bench aims at three areas: the two-edge write lag, the one-edge read lag, and forwarding where the two meet. Reads are placed one, two and three edges behind writes to the same word with partial byte masks. A design that read the array without forwarding would return the stale word with new lanes missing. A design that wrote at the wrong edge would store the random filler on dIn.

Stalls are inserted between a write command and its data, and across a held read result. A block that let ceN leak through would capture the filler or drop the held word. Bursts are run in both orders through the wrap, and advances are sent after deselects. A wrong counter shows up as reads from the wrong word, and a deselect that resumed would produce a spurious output or write. Dummy reads and mid-cycle oeN toggles check that drive follows oeN without waiting for a clock edge.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind_t;

  // strobes from control to datapath, valid for the current edge
  typedef struct packed {
    logic step;   // edge is enabled
    logic rdGo;   // a read is issued on this edge
    logic wrGo;   // a write is issued on this edge
  } strobe_t;

endpackage

// File: rtl/zt_sram_burst.sv
`timescale 1ns/1ps
module zt_sram_burst #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              step,
  input  logic              load,
  input  logic              advance,
  input  logic              xorMode,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] burstAddr
);

  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] beatCnt;
  logic [BURST_W-1:0] nextCnt;
  logic [BURST_W-1:0] lowNext;

  assign nextCnt = beatCnt + 1'b1;

  always_comb begin
    if (xorMode) lowNext = baseAddr[BURST_W-1:0] ^ nextCnt;
    else         lowNext = baseAddr[BURST_W-1:0] + nextCnt;
  end

  assign burstAddr = load ? startAddr : {baseAddr[ADDR_W-1:BURST_W], lowNext};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      beatCnt  <= '0;
    end else if (step && load) begin
      baseAddr <= startAddr;
      beatCnt  <= '0;
    end else if (step && advance) begin
      beatCnt  <= nextCnt;
    end
  end

  // R6
  burst_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step && advance && !load) |=> $stable(baseAddr));

endmodule

// File: rtl/zt_sram_ctrl.sv
`timescale 1ns/1ps
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ceN,
  input  logic             sel1N,
  input  logic             sel2,
  input  logic             sel3N,
  input  logic             advLd,
  input  logic             weN,
  input  logic [LANES-1:0] bwN,
  output strobe_t          strb,
  output logic             burstLoad,
  output logic             burstAdv,
  output logic [LANES-1:0] wrMask
);

  opKind_t prevOp;
  opKind_t curOp;
  logic    selOk;

  assign selOk = !sel1N && sel2 && !sel3N;

  always_comb begin
    curOp = OP_NONE;
    if (!advLd) begin
      if (selOk) curOp = weN ? OP_READ : OP_WRITE;
    end else begin
      curOp = prevOp;
    end
  end

  assign strb.step = !ceN;
  assign strb.rdGo = !ceN && (curOp == OP_READ);
  assign strb.wrGo = !ceN && (curOp == OP_WRITE);
  assign burstLoad = !advLd;
  assign burstAdv  = advLd && (prevOp != OP_NONE);
  assign wrMask    = ~bwN;

  always_ff @(posedge clk) begin
    if (!rstN)          prevOp <= OP_NONE;
    else if (strb.step) prevOp <= curOp;
  end

  // R1
  start_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.rdGo || strb.wrGo) && !advLd) |-> (!ceN && !sel1N && sel2 && !sel3N));

  // R7
  idle_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (advLd && prevOp == OP_NONE) |-> !(strb.rdGo || strb.wrGo));

  // R2
  hold_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    ceN |=> $stable(prevOp));

endmodule

// File: rtl/zt_sram_dpath.sv
`timescale 1ns/1ps
module zt_sram_dpath
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [ADDR_W-1:0]       opAddr,
  input  logic [LANES-1:0]        wrMask,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    oeN,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);

  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned WORD_W = LANES * LANE_W;

  // stage 1: command captured
  logic              rdV1, wrV1;
  logic [ADDR_W-1:0] addr1;
  logic [LANES-1:0]  mask1;
  // stage 2: write waiting for its data
  logic              wrV2;
  logic [ADDR_W-1:0] addr2;
  logic [LANES-1:0]  mask2;
  // output register
  logic [WORD_W-1:0] outReg;
  logic              outValid;

  logic [WORD_W-1:0] fwdWord;
  logic              fwdHit;

  assign fwdHit = wrV2 && (addr2 == addr1);

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] bank [DEPTH];
    logic [LANE_W-1:0] wrSlice;

    assign wrSlice = dIn[g*LANE_W +: LANE_W];

    always_ff @(posedge clk) begin
      if (strb.step && wrV2 && mask2[g]) bank[addr2] <= wrSlice;
    end

    assign fwdWord[g*LANE_W +: LANE_W] = (fwdHit && mask2[g]) ? wrSlice : bank[addr1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdV1     <= 1'b0;
      wrV1     <= 1'b0;
      addr1    <= '0;
      mask1    <= '0;
      wrV2     <= 1'b0;
      addr2    <= '0;
      mask2    <= '0;
      outReg   <= '0;
      outValid <= 1'b0;
    end else if (strb.step) begin
      rdV1     <= strb.rdGo;
      wrV1     <= strb.wrGo;
      addr1    <= opAddr;
      mask1    <= wrMask;
      wrV2     <= wrV1;
      addr2    <= addr1;
      mask2    <= mask1;
      outValid <= rdV1;
      if (rdV1) outReg <= fwdWord;
    end
  end

  assign dOut   = outReg;
  assign dOutEn = outValid && !oeN;

  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && rdV1) |=> outValid);

  // R4
  wr_lag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && wrV1) |=> wrV2);

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.step |=> ($stable(outReg) && $stable(outValid) && $stable(wrV2)));

  // R8
  drive_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    dOutEn |-> (!oeN && outValid));

endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned LANES   = 4,
  parameter int unsigned LANE_W  = 9,
  parameter int unsigned BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ceN,
  input  logic                    sel1N,
  input  logic                    sel2,
  input  logic                    sel3N,
  input  logic                    advLd,
  input  logic                    weN,
  input  logic [LANES-1:0]        bwN,
  input  logic                    burstXor,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    oeN,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);

  strobe_t           strb;
  logic              burstLoad;
  logic              burstAdv;
  logic [LANES-1:0]  wrMask;
  logic [ADDR_W-1:0] opAddr;

  zt_sram_ctrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN),
    .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N),
    .advLd(advLd), .weN(weN), .bwN(bwN),
    .strb(strb), .burstLoad(burstLoad), .burstAdv(burstAdv), .wrMask(wrMask)
  );

  zt_sram_burst #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk(clk), .rstN(rstN), .step(strb.step),
    .load(burstLoad), .advance(burstAdv), .xorMode(burstXor),
    .startAddr(addr), .burstAddr(opAddr)
  );

  zt_sram_dpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .opAddr(opAddr),
    .wrMask(wrMask), .dIn(dIn), .oeN(oeN),
    .dOut(dOut), .dOutEn(dOutEn)
  );

endmodule

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, ceN, sel1N, sel2, sel3N, advLd, weN, burstXor, oeN, dOutEn;
  logic [LN-1:0] bwN;
  logic [AW-1:0] addr;
  logic [DW-1:0] dIn, dOut;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .BURST_W(2)) u_zt_sram (
    .clk(clk), .rstN(rstN), .ceN(ceN), .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N),
    .advLd(advLd), .weN(weN), .bwN(bwN), .burstXor(burstXor), .addr(addr),
    .dIn(dIn), .oeN(oeN), .dOut(dOut), .dOutEn(dOutEn)
  );

  typedef struct { int due; logic [AW-1:0] a; logic [LN-1:0] m; logic [DW-1:0] d; } wItem_t;
  typedef struct { int due; logic [AW-1:0] a; string tag; } rItem_t;
  typedef enum { M_NONE, M_RD, M_WR } mop_t;

  wItem_t wq[$];
  rItem_t rq[$];
  logic [DW-1:0] model [64];
  int edgeCnt = 0, checks = 0, errs = 0, heldEdge = -1;
  logic [DW-1:0] heldData = '0;
  bit monOn = 1'b0;
  string curTag = "R11";
  mop_t mPrev = M_NONE;
  logic [AW-1:0] mBase = '0;
  logic [1:0] mN = '0;
  logic [DW-1:0] junk = 36'h3_1415_9265;

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finishUp();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i) * 36'h0_2468_ACE1 ^ 36'h9_0F00_F005;
  endfunction

  // one clock: drive at negedge+2, update the reference after the rising edge
  task automatic cyc(bit ce, bit s1n, bit s2v, bit s3n, bit adv, bit we,
                     logic [LN-1:0] bw, logic [AW-1:0] a, logic [DW-1:0] d, bit oe);
    logic [AW-1:0] cur;
    mop_t op;
    bit fire;
    @(negedge clk); #2;
    ceN = ce; sel1N = s1n; sel2 = s2v; sel3N = s3n; advLd = adv; weN = we;
    bwN = bw; addr = a; oeN = oe;
    fire = !ce && wq.size() > 0 && wq[0].due == edgeCnt + 1;
    junk = {junk[34:0], junk[35] ^ junk[30] ^ junk[2]};
    dIn = fire ? wq[0].d : junk;
    @(posedge clk); #1;
    if (!ce) begin
      edgeCnt++;
      if (fire) begin
        for (int i = 0; i < LN; i++)
          if (wq[0].m[i]) model[wq[0].a][i*LW +: LW] = wq[0].d[i*LW +: LW];
        void'(wq.pop_front());
      end
      op = M_NONE;
      cur = a;
      if (!adv) begin
        if (!s1n && s2v && !s3n) begin
          op = we ? M_RD : M_WR;
          mBase = a;
          mN = 2'd0;
        end
      end else if (mPrev != M_NONE) begin
        op = mPrev;
        mN = mN + 2'd1;
        cur = {mBase[AW-1:2], burstXor ? (mBase[1:0] ^ mN) : (mBase[1:0] + mN)};
      end
      mPrev = op;
      if (op == M_RD) rq.push_back('{edgeCnt + 1, cur, curTag});
      if (op == M_WR) wq.push_back('{edgeCnt + 2, cur, ~bw, d});
    end
  endtask

  task automatic rd(logic [AW-1:0] a);                         cyc(0,0,1,0,0,1,4'hF,a,'0,0); endtask
  task automatic rdDummy(logic [AW-1:0] a);                    cyc(0,0,1,0,0,1,4'hF,a,'0,1); endtask
  task automatic wr(logic [AW-1:0] a, logic [LN-1:0] bw, logic [DW-1:0] d); cyc(0,0,1,0,0,0,bw,a,d,0); endtask
  task automatic adv(logic [LN-1:0] bw, logic [DW-1:0] d);     cyc(0,1,0,1,1,0,bw,'0,d,0); endtask
  task automatic nop();                                        cyc(0,1,1,0,0,1,4'hF,'0,'0,0); endtask
  task automatic stall(bit oe);                                cyc(1,0,1,0,0,1,4'h0,6'd33,'0,oe); endtask

  // scoreboard monitor: pops expected reads as they fall due
  string mtag;
  always @(negedge clk) begin
    if (monOn) begin
      if (rq.size() > 0 && rq[0].due == edgeCnt) begin
        heldData = model[rq[0].a];
        heldEdge = edgeCnt;
        mtag = rq[0].tag;
        void'(rq.pop_front());
        if (!oeN) chk(dOutEn && dOut == heldData, mtag, dOut, heldData);
        else      chk(!dOutEn, {mtag, " R8"}, DW'(dOutEn), '0);
      end else if (heldEdge == edgeCnt) begin
        // R2: result held across a stalled edge
        if (!oeN) chk(dOutEn && dOut == heldData, "R2", dOut, heldData);
        else      chk(!dOutEn, "R2", DW'(dOutEn), '0);
      end else begin
        // R8: nothing held, so no drive
        chk(!dOutEn, {curTag, " R8"}, DW'(dOutEn), '0);
      end
    end
  end

  initial begin
    #4_000_000;
    checks++;
    errs++;
    $display("FAIL watchdog: actual running expected finished");
    finishUp();
  end

  initial begin
    rstN = 0; ceN = 0; sel1N = 1; sel2 = 0; sel3N = 1; advLd = 0; weN = 1;
    bwN = '1; addr = '0; dIn = '0; oeN = 0; burstXor = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2 rstN = 1;
    @(negedge clk);
    // R11
    chk(!dOutEn, "R11", DW'(dOutEn), '0);
    monOn = 1;

    // R4 / R10: fill the whole array back to back
    curTag = "R4";
    for (int i = 0; i < 64; i++) wr(6'(i), 4'h0, pat(i));
    nop(); nop();

    // R3: single reads
    curTag = "R3";
    rd(6'd3); rd(6'd60); nop(); rd(6'd17); nop(); nop();

    // R4: byte-lane writes
    curTag = "R4";
    wr(6'd4, 4'b1110, 36'h1_1111_1111);
    wr(6'd5, 4'b0111, 36'h2_2222_2222);
    wr(6'd6, 4'b1010, 36'h3_3333_3333);
    nop(); nop();
    rd(6'd4); rd(6'd5); rd(6'd6); nop(); nop();

    // R9: forwarding at distances one, two and three
    curTag = "R9";
    wr(6'd20, 4'b0101, 36'hA_BCDE_F012); rd(6'd20); nop(); nop();
    wr(6'd21, 4'b0000, 36'h5_5555_AAAA); nop(); rd(6'd21); nop(); nop();
    wr(6'd22, 4'b1001, 36'h7_7777_7777); rd(6'd22); rd(6'd22); rd(6'd22); nop(); nop();

    // R10: alternating without idle cycles
    curTag = "R10";
    for (int i = 0; i < 6; i++) begin
      wr(6'(24 + i), 4'h0, pat(100 + i));
      rd(6'(24 + i));
    end
    nop(); nop();

    // R5: write abort
    curTag = "R5";
    wr(6'd40, 4'hF, 36'hF_FFFF_FFFF); nop(); nop(); rd(6'd40); nop(); nop();
    wr(6'd41, 4'h0, 36'h0_1234_5678); adv(4'hF, 36'hE_EEEE_EEEE); nop(); nop();
    rd(6'd41); rd(6'd42); nop(); nop();

    // R6: bursts in both orders, through the wrap
    curTag = "R6";
    burstXor = 0;
    rd(6'h0A); adv(4'h0, '0); adv(4'h0, '0); adv(4'h0, '0); adv(4'h0, '0); nop(); nop();
    wr(6'h11, 4'h0, 36'hC_0000_0001); adv(4'h0, 36'hC_0000_0002);
    adv(4'b1100, 36'hC_0000_0003); adv(4'h0, 36'hC_0000_0004); nop(); nop();
    rd(6'h10); rd(6'h11); rd(6'h12); rd(6'h13); nop(); nop();
    burstXor = 1;
    rd(6'h0E); adv(4'h0, '0); adv(4'h0, '0); adv(4'h0, '0); nop(); nop();
    wr(6'h35, 4'h0, 36'hD_0000_0001); adv(4'h0, 36'hD_0000_0002); adv(4'h0, 36'hD_0000_0003);
    nop(); nop();
    rd(6'h34); rd(6'h35); rd(6'h36); rd(6'h37); nop(); nop();
    burstXor = 0;

    // R1: each select wrong on its own, then a read-back
    curTag = "R1";
    cyc(0,1,1,0,0,0,4'h0,6'd30,36'h0_DEAD_0001,0);
    cyc(0,0,0,0,0,0,4'h0,6'd30,36'h0_DEAD_0002,0);
    cyc(0,0,1,1,0,0,4'h0,6'd30,36'h0_DEAD_0003,0);
    cyc(0,1,0,1,0,1,4'hF,6'd31,'0,0);
    nop(); nop(); rd(6'd30); nop(); nop();

    // R7: advance right after a deselect
    curTag = "R7";
    nop(); adv(4'h0, 36'h0_BAD0_0BAD); cyc(0,1,0,1,1,1,4'hF,'0,'0,0); nop(); nop();
    rd(6'd31); rd(6'd32); nop(); nop();

    // R2: stalls across a held read and between write command and data
    curTag = "R2";
    rd(6'd5); nop(); stall(0); stall(0); nop();
    wr(6'd50, 4'h0, 36'h6_6666_0050); stall(0); stall(0); nop(); nop();
    rd(6'd50); nop(); nop();
    cyc(1,0,1,0,0,0,4'h0,6'd51,36'h0_BAD0_0051,0); nop(); nop();
    rd(6'd51); nop(); nop();

    // R8: asynchronous output enable and dummy read
    curTag = "R8";
    rd(6'd9); nop(); stall(0);
    oeN = 1; #1;
    chk(!dOutEn, "R8", DW'(dOutEn), '0);
    oeN = 0; #1;
    chk(dOutEn && dOut == model[9], "R8", dOut, model[9]);
    rdDummy(6'd12); cyc(0,1,1,0,0,1,4'hF,'0,'0,1);
    stall(0); nop(); nop();

    #5;
    chk(rq.size() == 0 && wq.size() == 0, "R3", DW'(rq.size()), '0);
    finishUp();
  end
endmodule